// File: doc/BRIEF.md
# Parallel i80 LCD Write Sequencer

This block sends one frame of pixel data to a display panel over a CPU-style (i80) parallel write bus. The panel keeps its own frame memory, so the block only writes when it is told to. A frame starts on a trigger. The trigger is either a software command written through the configuration port, or a rising edge on the panel's tearing-effect input. Pixels arrive on a valid/ready stream. Each pixel is written to the panel in one bus cycle. That cycle has four phases whose lengths software sets: chip-select setup, write-strobe setup, write-strobe active and write-strobe hold.

When the last pixel of the frame has been written, a frame-done flag is raised and drives the interrupt output. The block stays in its triggering state until software writes a 1 to clear that flag. While it is in the triggering state, any further trigger is dropped, because a repeated trigger can reset the panel. The timing word and the frame size are captured when the trigger is taken. Later register writes therefore never change a frame that is already running.

The register port is write-only and holds four words:
- address 0, timing;
- address 1, trigger control;
- address 2, frame size;
- address 3, flag clear.

Top module: `lcd_i80_writer`

## Requirements
- R1: After reset, lcd_cs_n and lcd_wr_n are 1, lcd_rs is 0, pix_ready is 0 and done_irq is 0.
- R2: The timing word (address 0) holds four 4-bit phase lengths:
  - CS setup at bits 19:16;
  - WR setup at bits 15:12;
  - WR active at bits 11:8;
  - WR hold at bits 7:4.

  A field value v lasts v+1 clock cycles. For each pixel:
  - lcd_cs_n falls CS-setup + WR-setup + 2 cycles before lcd_wr_n falls;
  - lcd_wr_n stays low for WR-active + 1 cycles;
  - lcd_cs_n rises WR-hold + 1 cycles after lcd_wr_n rises.
- R3: lcd_wr_n is low only while lcd_cs_n is low. lcd_rs is 1 whenever lcd_cs_n is low. lcd_data stays constant while lcd_cs_n is low.
- R4: Bit 0 of the timing word enables the interface. While it is 0, no trigger is taken and lcd_cs_n never falls.
- R5: Trigger control is address 1. When trigger-mode enable (bit 0) is 1 and tearing-effect triggering (bit 3) is 0, writing a 1 to the software-command bit (bit 1) starts a frame.
- R6: While trigger-mode enable (bit 0) is 0, neither the software command nor a tearing-effect edge starts a frame.
- R7: When bit 3 and the per-edge enable (bit 31) are both 1, every rising edge of te_in outside the triggering state starts a frame.
- R8: When bit 3 is 1 and bit 31 is 0:
  - a te_in edge alone starts nothing;
  - a software command does not start a frame itself but arms one;
  - the next te_in rising edge then starts the armed frame.
- R9: While the tearing-effect mask (bit 4) is 1, te_in edges start no frame.
- R10: A trigger that arrives while a frame is in flight, or while the frame-done flag is pending, is dropped and not queued.
- R11: Frame size is address 2, with width-1 at bits DIM_W-1:0 and height-1 at bits 16+DIM_W-1:16. A frame is exactly width×height pixel writes. done_irq rises in the same cycle that lcd_cs_n rises after the last write, and not before.
- R12: Writing address 3 with bit 0 set clears the frame-done flag, and the block leaves the triggering state. The same write has no effect while the flag is clear.
- R13: pix_ready is 1 only between pixel writes of an active frame. A stalled stream holds the bus idle without losing pixels, and pixels are written in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| te_in | input | 1 | Tearing-effect input from the panel |
| pix_valid | input | 1 | Pixel stream valid |
| pix_data | input | DATA_W | Pixel stream data |
| pix_ready | output | 1 | Pixel stream ready |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_rs | output | 1 | Register/data select, 1 for pixel data |
| lcd_data | output | DATA_W | Panel data bus |
| done_irq | output | 1 | Frame-done interrupt flag |

## Verification
The assertions check, on every cycle, the relations between parts of the block:
- the strobe lies inside chip select, and data holds steady while chip select is low;
- chip select never falls while the interface is disabled;
- the sequencer is active only inside the triggering state;
- the flag rises only at a frame end and falls only on a clear write.

The exact phase lengths, the pixel count and order under stalls, and the cases where the trigger rules must refuse to start a frame can only be shown by the bench's scenarios. The bench shows them by timing every write against the programmed fields and by watching the bus stay idle when a frame must not start.

// File: rtl/lcdseq_pkg.sv
// Package: shared field positions, register addresses and types for the
// i80 write sequencer. Assumes a 32-bit register word.
package lcdseq_pkg;
    localparam int PH_W = 4;

    // timing word layout
    localparam int TM_EN_BIT  = 0;
    localparam int TM_CSS_LSB = 16;
    localparam int TM_WRS_LSB = 12;
    localparam int TM_WRA_LSB = 8;
    localparam int TM_WRH_LSB = 4;

    // trigger control layout
    localparam int TC_MODE_BIT  = 0;
    localparam int TC_SW_BIT    = 1;
    localparam int TC_HWEN_BIT  = 3;
    localparam int TC_MASK_BIT  = 4;
    localparam int TC_PERTE_BIT = 31;

    // frame size layout
    localparam int SZ_H_LSB = 16;

    // word addresses
    localparam logic [1:0] ADDR_TIMING = 2'd0;
    localparam logic [1:0] ADDR_TRIG   = 2'd1;
    localparam logic [1:0] ADDR_SIZE   = 2'd2;
    localparam logic [1:0] ADDR_CLEAR  = 2'd3;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CSS  = 3'd1,
        PH_WRS  = 3'd2,
        PH_WRA  = 3'd3,
        PH_WRH  = 3'd4
    } phase_e;

    typedef struct packed {
        logic [PH_W-1:0] css;
        logic [PH_W-1:0] wrs;
        logic [PH_W-1:0] wra;
        logic [PH_W-1:0] wrh;
    } phase_cfg_t;
endpackage

// File: rtl/lcdseq_cfg_regs.sv
// Configuration registers.
// Holds the timing word, the trigger controls and the frame size. It also
// turns the software-command bit and the flag-clear bit into one-cycle
// pulses, delayed by one register stage. Assumes DIM_W < 16 so both size
// fields fit in their halves of the word.
module lcdseq_cfg_regs
    import lcdseq_pkg::*;
#(
    parameter int DIM_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic             if_en,
    output phase_cfg_t       tcfg,
    output logic             tmode,
    output logic             hw_en,
    output logic             te_mask,
    output logic             per_te,
    output logic [DIM_W-1:0] w_m1,
    output logic [DIM_W-1:0] h_m1,
    output logic             sw_pulse,
    output logic             clr_pulse
);
    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    // Register writes and command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_en     <= 1'b0;
            tcfg      <= '0;
            tmode     <= 1'b0;
            hw_en     <= 1'b0;
            te_mask   <= 1'b0;
            per_te    <= 1'b0;
            w_m1      <= '0;
            h_m1      <= '0;
            sw_pulse  <= 1'b0;
            clr_pulse <= 1'b0;
        end else begin
            sw_pulse  <= 1'b0;
            clr_pulse <= 1'b0;
            if (cfg_we) begin
                case (cfg_addr)
                    ADDR_TIMING: begin
                        if_en    <= cfg_wdata[TM_EN_BIT];
                        tcfg.css <= cfg_wdata[TM_CSS_LSB +: PH_W];
                        tcfg.wrs <= cfg_wdata[TM_WRS_LSB +: PH_W];
                        tcfg.wra <= cfg_wdata[TM_WRA_LSB +: PH_W];
                        tcfg.wrh <= cfg_wdata[TM_WRH_LSB +: PH_W];
                    end
                    ADDR_TRIG: begin
                        tmode    <= cfg_wdata[TC_MODE_BIT];
                        hw_en    <= cfg_wdata[TC_HWEN_BIT];
                        te_mask  <= cfg_wdata[TC_MASK_BIT];
                        per_te   <= cfg_wdata[TC_PERTE_BIT];
                        sw_pulse <= cfg_wdata[TC_SW_BIT];
                    end
                    ADDR_SIZE: begin
                        w_m1 <= cfg_wdata[DIM_W-1:0];
                        h_m1 <= cfg_wdata[SZ_H_LSB +: DIM_W];
                    end
                    default: clr_pulse <= cfg_wdata[0];
                endcase
            end
        end
    end
endmodule

// File: rtl/lcdseq_trig.sv
// Trigger arbiter.
// Decides when a frame starts, from the software command and the
// tearing-effect edge. Holds the triggering state from the start of a frame
// until the frame-done flag is cleared, and drops every trigger in between.
// Assumes te_in is already synchronous to clk.
module lcdseq_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic tmode,
    input  logic hw_en,
    input  logic te_mask,
    input  logic per_te,
    input  logic if_en,
    input  logic sw_pulse,
    input  logic clr_pulse,
    input  logic te_in,
    input  logic frame_end,
    output logic start,
    output logic trig_state,
    output logic done_flag
);
    logic te_q;
    logic sw_pend;
    logic te_hit;
    logic go_ok;

    always_comb begin
        te_hit = hw_en & ~te_mask & te_in & ~te_q;
        go_ok  = tmode & if_en & ~trig_state;
        start  = go_ok & ((sw_pulse & ~hw_en) | (te_hit & (per_te | sw_pend)));
    end

    // Delay te_in by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) te_q <= 1'b0;
        else        te_q <= te_in;
    end

    // Arm a software request that waits for the next tearing-effect edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sw_pend <= 1'b0;
        else if (start || !hw_en)   sw_pend <= 1'b0;
        else if (sw_pulse && go_ok) sw_pend <= 1'b1;
    end

    // Triggering state: entered on start, left on a clear of a pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        trig_state <= 1'b0;
        else if (start)                                    trig_state <= 1'b1;
        else if (clr_pulse && done_flag && !frame_end)     trig_state <= 1'b0;
    end

    // Frame-done flag: set at frame end, cleared by a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n)         done_flag <= 1'b0;
        else if (frame_end) done_flag <= 1'b1;
        else if (clr_pulse) done_flag <= 1'b0;
    end

    // R11
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(frame_end))
        else $error("done flag rose without a frame end");

    // R12
    trig_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_state) |-> ($past(done_flag) && $past(clr_pulse)))
        else $error("triggering state left without a flag clear");
endmodule

// File: rtl/lcdseq_phase.sv
// Write-cycle sequencer.
// Takes pixels from the stream one at a time and steps each pixel through
// the chip-select setup, write setup, write active and write hold phases.
// Counts the pixels of the frame and flags the end of the last write.
// Assumes start is only given while no frame is active. Timing and size are
// captured at start.
module lcdseq_phase
    import lcdseq_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DIM_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              if_en,
    input  phase_cfg_t        tcfg,
    input  logic [DIM_W-1:0]  w_m1,
    input  logic [DIM_W-1:0]  h_m1,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              pix_ready,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic              lcd_rs,
    output logic [DATA_W-1:0] lcd_data,
    output logic              frame_end,
    output logic              active
);
    localparam logic [DIM_W-1:0] DIM_ONE = 1;
    localparam logic [PH_W-1:0]  CNT_ONE = 1;

    phase_e            state;
    logic [PH_W-1:0]   cnt;
    phase_cfg_t        cfg_q;
    logic [DIM_W-1:0]  w_q, h_q, col, row;
    logic              last_q;
    logic              active_q;
    logic [DATA_W-1:0] data_q;
    logic              accept;
    logic              phase_done;

    assign phase_done = (cnt == '0);
    assign pix_ready  = active_q && (state == PH_IDLE) && if_en;
    assign accept     = pix_ready && pix_valid;
    assign frame_end  = (state == PH_WRH) && phase_done && last_q;
    assign lcd_cs_n   = (state == PH_IDLE);
    assign lcd_wr_n   = (state != PH_WRA);
    assign lcd_rs     = active_q;
    assign lcd_data   = data_q;
    assign active     = active_q;

    // Capture timing and frame size when the frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            w_q   <= '0;
            h_q   <= '0;
        end else if (start) begin
            cfg_q <= tcfg;
            w_q   <= w_m1;
            h_q   <= h_m1;
        end
    end

    // Frame activity: from start to the end of the last write.
    always_ff @(posedge clk) begin
        if (!rst_n)         active_q <= 1'b0;
        else if (start)     active_q <= 1'b1;
        else if (frame_end) active_q <= 1'b0;
    end

    // Column/row position and last-pixel marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col    <= '0;
            row    <= '0;
            last_q <= 1'b0;
        end else if (start) begin
            col    <= '0;
            row    <= '0;
            last_q <= 1'b0;
        end else if (accept) begin
            last_q <= (col == w_q) && (row == h_q);
            if (col == w_q) begin
                col <= '0;
                row <= row + DIM_ONE;
            end else begin
                col <= col + DIM_ONE;
            end
        end
    end

    // Phase state machine and per-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                PH_IDLE: if (accept) begin
                    state <= PH_CSS;
                    cnt   <= cfg_q.css;
                end
                PH_CSS: if (phase_done) begin
                    state <= PH_WRS;
                    cnt   <= cfg_q.wrs;
                end else cnt <= cnt - CNT_ONE;
                PH_WRS: if (phase_done) begin
                    state <= PH_WRA;
                    cnt   <= cfg_q.wra;
                end else cnt <= cnt - CNT_ONE;
                PH_WRA: if (phase_done) begin
                    state <= PH_WRH;
                    cnt   <= cfg_q.wrh;
                end else cnt <= cnt - CNT_ONE;
                PH_WRH: if (phase_done) begin
                    state <= PH_IDLE;
                end else cnt <= cnt - CNT_ONE;
                default: state <= PH_IDLE;
            endcase
        end
    end

    // Pixel holding register for the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= pix_data;
    end

    // R3
    wr_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n |-> (!lcd_cs_n && lcd_rs))
        else $error("write strobe outside chip select");

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_data))
        else $error("data changed during a write cycle");

    // R4
    cs_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_cs_n) |-> $past(if_en))
        else $error("write started while interface disabled");

    // R13
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |=> (lcd_data == $past(pix_data)))
        else $error("accepted pixel not placed on the bus");

    // R10
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active_q)
        else $error("start while a frame is active");
endmodule

// File: rtl/lcd_i80_writer.sv
// Top level of the i80 write sequencer.
// Connects the register block, the trigger arbiter and the write-cycle
// sequencer. The frame-done flag drives done_irq directly.
module lcd_i80_writer
    import lcdseq_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DIM_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              te_in,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              pix_ready,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic              lcd_rs,
    output logic [DATA_W-1:0] lcd_data,
    output logic              done_irq
);
    logic             if_en, tmode, hw_en, te_mask, per_te;
    logic             sw_pulse, clr_pulse;
    logic             start, trig_state, done_flag, frame_end, active;
    phase_cfg_t       tcfg;
    logic [DIM_W-1:0] w_m1, h_m1;

    lcdseq_cfg_regs #(.DIM_W(DIM_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .if_en(if_en), .tcfg(tcfg), .tmode(tmode), .hw_en(hw_en),
        .te_mask(te_mask), .per_te(per_te), .w_m1(w_m1), .h_m1(h_m1),
        .sw_pulse(sw_pulse), .clr_pulse(clr_pulse)
    );

    lcdseq_trig u_trig (
        .clk(clk), .rst_n(rst_n),
        .tmode(tmode), .hw_en(hw_en), .te_mask(te_mask), .per_te(per_te),
        .if_en(if_en), .sw_pulse(sw_pulse), .clr_pulse(clr_pulse),
        .te_in(te_in), .frame_end(frame_end),
        .start(start), .trig_state(trig_state), .done_flag(done_flag)
    );

    lcdseq_phase #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .start(start), .if_en(if_en), .tcfg(tcfg),
        .w_m1(w_m1), .h_m1(h_m1),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_rs(lcd_rs),
        .lcd_data(lcd_data), .frame_end(frame_end), .active(active)
    );

    assign done_irq = done_flag;

    // R10
    active_in_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> trig_state)
        else $error("sequencer active outside the triggering state");
endmodule

// File: tb/lcd_i80_writer_tb.sv
`timescale 1ns/100ps
module lcd_i80_writer_tb;
    localparam int DATA_W = 18;
    localparam int DIM_W  = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              te_in = 1'b0;
    logic              pix_valid = 1'b0;
    logic [DATA_W-1:0] pix_data = '0;
    logic              pix_ready, lcd_cs_n, lcd_wr_n, lcd_rs, done_irq;
    logic [DATA_W-1:0] lcd_data;

    lcd_i80_writer #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .te_in(te_in), .pix_valid(pix_valid),
        .pix_data(pix_data), .pix_ready(pix_ready), .lcd_cs_n(lcd_cs_n),
        .lcd_wr_n(lcd_wr_n), .lcd_rs(lcd_rs), .lcd_data(lcd_data),
        .done_irq(done_irq)
    );

    always #2.5 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    // expected behaviour, set by the scenarios
    int  exp_a = 2, exp_b = 1, exp_c = 1;
    int  exp_frame_px = 0;
    int  px_seen = 0;
    logic [DATA_W-1:0] exp_q[$];

    bit  feed_en = 0;
    bit  gap_mode = 0;
    int  cyc = 0;
    logic [DATA_W-1:0] next_val = 18'h00100;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Stream source: offers pixels and records every accepted one.
    always @(negedge clk) begin
        cyc++;
        pix_valid = feed_en && !(gap_mode && (cyc % 3 != 0));
        pix_data  = next_val;
        #1;
        if (pix_valid && pix_ready) begin
            exp_q.push_back(pix_data);
            next_val = next_val + 18'd7;
        end
    end

    // Bus monitor: times each write cycle against the programmed phases.
    int ph = 0;
    int n = 0;
    logic [DATA_W-1:0] seen_data;
    bit  shape_bad = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            ph = 0;
        end else begin
            if (!lcd_wr_n && lcd_cs_n) shape_bad = 1;
            if (!lcd_cs_n && !lcd_rs) shape_bad = 1;
            case (ph)
                0: if (!lcd_cs_n) begin ph = 1; n = 1; seen_data = lcd_data; shape_bad = !lcd_wr_n; end
                1: begin
                    if (lcd_data != seen_data) shape_bad = 1;
                    if (!lcd_wr_n) begin
                        chk("R2", "cs-to-wr cycles", n, exp_a);
                        ph = 2; n = 1;
                    end else n++;
                end
                2: begin
                    if (lcd_data != seen_data) shape_bad = 1;
                    if (lcd_wr_n) begin
                        chk("R2", "wr low cycles", n, exp_b);
                        ph = 3; n = 1;
                    end else n++;
                end
                default: begin
                    if (lcd_cs_n) begin
                        logic [DATA_W-1:0] want;
                        chk("R2", "wr-to-cs cycles", n, exp_c);
                        chk("R3", "strobe/rs/data shape ok", shape_bad, 0);
                        px_seen++;
                        chk("R11", "pixels within frame", px_seen <= exp_frame_px, 1);
                        want = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
                        chk("R13", "pixel data in order", seen_data, want);
                        chk("R11", "done_irq at write end", done_irq, px_seen == exp_frame_px);
                        ph = 0;
                    end else begin
                        if (lcd_data != seen_data) shape_bad = 1;
                        n++;
                    end
                end
            endcase
        end
    end

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic set_timing(input int en, input int css, input int wrs, input int wra, input int wrh);
        exp_a = css + wrs + 2; exp_b = wra + 1; exp_c = wrh + 1;
        cfg_write(2'd0, (css << 16) | (wrs << 12) | (wra << 8) | (wrh << 4) | en);
    endtask

    task automatic set_size(input int w, input int h);
        exp_frame_px = w * h;
        cfg_write(2'd2, ((h - 1) << 16) | (w - 1));
    endtask

    task automatic new_frame();
        px_seen = 0;
    endtask

    task automatic clear_flag();
        cfg_write(2'd3, 32'h1);
        repeat (2) @(negedge clk);
    endtask

    task automatic te_pulse();
        @(negedge clk); te_in = 1'b1;
        repeat (3) @(negedge clk);
        te_in = 1'b0;
    endtask

    task automatic wait_done(input string req, input int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (done_irq) break;
        end
        chk(req, "done_irq raised", done_irq, 1);
        @(negedge clk);
        chk(req, "pixel count of frame", px_seen, exp_frame_px);
    endtask

    task automatic quiet(input string req, input int cycles, input int irq_exp);
        int lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!lcd_cs_n || pix_ready) lows++;
        end
        chk(req, "bus stays idle", lows, 0);
        chk(req, "done_irq level", done_irq, irq_exp);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1", "cs_n", lcd_cs_n, 1);
        chk("R1", "wr_n", lcd_wr_n, 1);
        chk("R1", "rs", lcd_rs, 0);
        chk("R1", "pix_ready", pix_ready, 0);
        chk("R1", "done_irq", done_irq, 0);
        rst_n = 1'b1;
        feed_en = 1;

        // R4: interface disabled, software trigger does nothing
        set_timing(0, 0, 0, 0, 0);
        set_size(2, 2);
        cfg_write(2'd1, 32'h3);
        quiet("R4", 40, 0);

        // R5/R2/R11: minimal phases, 3x2 frame, software trigger
        set_timing(1, 0, 0, 0, 0);
        set_size(3, 2);
        new_frame();
        cfg_write(2'd1, 32'h3);
        repeat (8) @(negedge clk);
        cfg_write(2'd1, 32'h3);          // R10: mid-frame trigger dropped
        wait_done("R5", 200);
        quiet("R10", 30, 1);
        cfg_write(2'd1, 32'h3);          // R10: trigger with flag pending dropped
        quiet("R10", 30, 1);
        clear_flag();
        chk("R12", "flag cleared", done_irq, 0);
        quiet("R12", 30, 0);

        // R2/R13: longer phases, stalled stream
        set_timing(1, 2, 1, 3, 2);
        set_size(4, 1);
        gap_mode = 1;
        new_frame();
        cfg_write(2'd1, 32'h3);
        wait_done("R13", 400);
        clear_flag();
        gap_mode = 0;

        // R9: masked tearing edge
        set_timing(1, 1, 0, 1, 0);
        set_size(2, 1);
        cfg_write(2'd1, 32'h8000_0019);
        te_pulse();
        quiet("R9", 30, 0);

        // R7: every tearing edge starts a frame
        cfg_write(2'd1, 32'h8000_0009);
        new_frame();
        te_pulse();
        wait_done("R7", 200);
        clear_flag();
        new_frame();
        te_pulse();
        wait_done("R7", 200);
        clear_flag();

        // R8: edge alone ignored, software command waits for edge
        cfg_write(2'd1, 32'h0000_0009);
        te_pulse();
        quiet("R8", 30, 0);
        cfg_write(2'd1, 32'h0000_000B);
        quiet("R8", 20, 0);
        new_frame();
        te_pulse();
        wait_done("R8", 200);
        clear_flag();

        // R6: trigger mode off
        cfg_write(2'd1, 32'h2);
        quiet("R6", 30, 0);
        cfg_write(2'd1, 32'h8000_0008);
        te_pulse();
        quiet("R6", 30, 0);

        // R12: clear without pending flag has no effect; trigger still works
        clear_flag();
        chk("R12", "irq after idle clear", done_irq, 0);
        new_frame();
        cfg_write(2'd1, 32'h3);
        wait_done("R12", 200);
        clear_flag();
        quiet("R12", 20, 0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    end
endmodule